// File: doc/BRIEF.md
# Aging Priority Write-Port Arbiter

This block picks one of several write ports each cycle and hands it the single command input of a memory controller. Every port presents a request, the bank and row its command targets, and an urgent sideband line. While the block is in reset it captures a set of per-port settings: page-match enable, urgent enable, aging enable and a 10-bit aging load value. After reset those settings stay fixed until the next reset.

A grant is made in one of four ways, strongest first. An enabled urgent port wins outright, and a registered critical flag goes high with its grant. A port whose aging counter has run down to zero wins next. A port that holds the grant through page matching keeps it, unless an urgent or fully aged port appears on another port. Otherwise a round-robin pointer shares the grant among the requesting ports. Page-match holding keeps the last granted port while its next back-to-back command targets the same bank and row. A programmable hit limit stops that hold from starving the other ports.

The grant is a registered one-hot vector that reflects the request inputs sampled one clock earlier.

Top module: `wr_age_arbiter`

## Requirements
- R1: When `rst` is high at a clock edge, `grant` and `critical` become 0 and the configuration inputs are captured. Configuration inputs that change while `rst` is low have no effect.
- R2: `grant` is one-hot or zero and is registered. The grant after an edge goes only to a port whose `req_valid` bit was high before that edge. It is all zero when no port requested.
- R3: Without urgent, aged or held ports, grants rotate round-robin. The search starts at the port after the last granted one, and the pointer starts at port 0 after reset.
- R4: A requesting port with urgent enabled and its `urgent_in` bit high is granted ahead of all others. `critical` is high in the same cycle as that grant.
- R5: `urgent_in` on a port whose urgent enable is clear changes neither the grant order nor `critical`.
- R6: Each port's aging counter loads `{prio[9:2],2'b00}` at reset and whenever that port is granted. It decrements once per cycle while the port requests and is not granted, and it stops at zero. A requesting port with aging enabled and a zero counter outranks the round-robin ports and ends any page-match hold.
- R7: With aging enable clear, a port's counter state never changes its priority.
- R8: With page match enabled on the last granted port, that port keeps the grant while it keeps requesting with the same bank and row as its previous granted command.
- R9: A change of bank or row on the held port ends the hold, and the round-robin choice applies.
- R10: A page-match hold covers at most `HOLD_MAX` consecutive repeat grants. After that, the round-robin choice applies.
- R11: An urgent request on another port ends a page-match hold in the same cycle and takes the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| req_valid | input | NPORTS | Per-port write request |
| req_bank | input | NPORTS*BANK_W | Per-port bank of the pending command, port i at bits [i*BANK_W +: BANK_W] |
| req_row | input | NPORTS*ROW_W | Per-port row of the pending command, port i at bits [i*ROW_W +: ROW_W] |
| urgent_in | input | NPORTS | Per-port urgent sideband |
| cfg_pm_en | input | NPORTS | Page-match enable per port |
| cfg_urg_en | input | NPORTS | Urgent enable per port |
| cfg_age_en | input | NPORTS | Aging enable per port |
| cfg_prio | input | NPORTS*10 | Aging load value per port, port i at bits [i*10 +: 10] |
| grant | output | NPORTS | Registered one-hot grant |
| critical | output | 1 | High with a grant given to an enabled urgent port |

## Verification
Page-match holding can fall in the same cycle as an urgent request or a zero aging counter on another port. Either of these must break the hold. The bench keeps one port holding on a fixed bank and row, then raises urgent on a second port, or lets a second port's counter run down to zero. It then checks that the grant moves in exactly that cycle, with `critical` following the urgent case. A second overlap, urgent on a port whose urgent enable is clear, is judged by checking that the round-robin order continues and `critical` stays low.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  localparam int PRIO_W = 10;

  // Low two bits of the aging load are always treated as zero.
  function automatic logic [PRIO_W-1:0] age_load(input logic [PRIO_W-1:0] p);
    return {p[PRIO_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/wpa_age_counter.sv
module wpa_age_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] load_val,
  input  logic         age_en,
  input  logic         req,
  input  logic         gnt,
  output logic         aged
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || gnt)
      cnt <= load_val;
    else if (age_en && req && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign aged = age_en && (cnt == '0);

  AST_AGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    $past(gnt) && !$past(rst) |-> cnt == $past(load_val)); // R6
  AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(gnt) && $past(cnt) == '0 |-> cnt == '0); // R6
endmodule

// File: rtl/wpa_rr_pick.sv
module wpa_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  pick
);
  always_comb begin
    pick = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (cand[idx]) begin
        pick = '0;
        pick[idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_age_arbiter.sv
module wr_age_arbiter
  import wpa_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14,
  parameter int HOLD_MAX = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*BANK_W-1:0] req_bank,
  input  logic [NPORTS*ROW_W-1:0]  req_row,
  input  logic [NPORTS-1:0]        urgent_in,
  input  logic [NPORTS-1:0]        cfg_pm_en,
  input  logic [NPORTS-1:0]        cfg_urg_en,
  input  logic [NPORTS-1:0]        cfg_age_en,
  input  logic [NPORTS*PRIO_W-1:0] cfg_prio,
  output logic [NPORTS-1:0]        grant,
  output logic                     critical
);
  localparam int TAG_W = BANK_W + ROW_W;
  localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int HC_W  = $clog2(HOLD_MAX + 1);
  localparam int NLVL  = 3;

  logic [NPORTS-1:0] pm_q, urg_q, age_q;
  logic [PRIO_W-1:0] prio_q [NPORTS];
  logic [TAG_W-1:0]  tag    [NPORTS];
  logic [PRIO_W-1:0] ld_val [NPORTS];

  logic [NPORTS-1:0] aged_raw, urg_set, aged_set, gnt_nxt;
  logic [NPORTS-1:0] lvl  [NLVL];
  logic [NPORTS-1:0] pick [NLVL];

  logic [IW-1:0]     rr_ptr, last_idx, nxt_idx;
  logic [TAG_W-1:0]  tag_q;
  logic [HC_W-1:0]   hold_cnt;
  logic              hold_ok;

  // Configuration capture while in reset only
  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q  <= cfg_pm_en;
      urg_q <= cfg_urg_en;
      age_q <= cfg_age_en;
      for (int i = 0; i < NPORTS; i++)
        prio_q[i] <= cfg_prio[i*PRIO_W +: PRIO_W];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPORTS; gi++) begin : g_port
      assign tag[gi]    = {req_bank[gi*BANK_W +: BANK_W], req_row[gi*ROW_W +: ROW_W]};
      assign ld_val[gi] = rst ? age_load(cfg_prio[gi*PRIO_W +: PRIO_W])
                              : age_load(prio_q[gi]);
      wpa_age_counter #(.W(PRIO_W)) u_age (
        .clk      (clk),
        .rst      (rst),
        .load_val (ld_val[gi]),
        .age_en   (age_q[gi]),
        .req      (req_valid[gi]),
        .gnt      (gnt_nxt[gi]),
        .aged     (aged_raw[gi])
      );
    end
  endgenerate

  assign urg_set  = urg_q & urgent_in & req_valid;
  assign aged_set = aged_raw & req_valid;
  assign lvl[0]   = urg_set;
  assign lvl[1]   = aged_set;
  assign lvl[2]   = req_valid;

  generate
    for (gi = 0; gi < NLVL; gi++) begin : g_lvl
      wpa_rr_pick #(.N(NPORTS)) u_pick (
        .cand (lvl[gi]),
        .ptr  (rr_ptr),
        .pick (pick[gi])
      );
    end
  endgenerate

  // Page-match hold: same port, same bank and row, under the hit limit,
  // and no urgent or aged request on any other port
  always_comb begin
    hold_ok = (|grant) && pm_q[last_idx] && req_valid[last_idx]
              && (tag[last_idx] == tag_q)
              && (hold_cnt < HC_W'(HOLD_MAX))
              && !(|((urg_set | aged_set) & ~grant));
  end

  always_comb begin
    if (rst)            gnt_nxt = '0;
    else if (hold_ok)   gnt_nxt = grant;
    else if (|urg_set)  gnt_nxt = pick[0];
    else if (|aged_set) gnt_nxt = pick[1];
    else                gnt_nxt = pick[2];
  end

  always_comb begin
    nxt_idx = '0;
    for (int i = 0; i < NPORTS; i++)
      if (gnt_nxt[i]) nxt_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= '0;
      critical <= 1'b0;
      rr_ptr   <= '0;
      last_idx <= '0;
      tag_q    <= '0;
      hold_cnt <= '0;
    end else begin
      grant    <= gnt_nxt;
      critical <= |(gnt_nxt & urg_q & urgent_in);
      if (|gnt_nxt) begin
        last_idx <= nxt_idx;
        tag_q    <= tag[nxt_idx];
        rr_ptr   <= (int'(nxt_idx) == NPORTS - 1) ? '0 : nxt_idx + 1'b1;
        hold_cnt <= hold_ok ? hold_cnt + 1'b1 : '0;
      end else begin
        hold_cnt <= '0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    |grant |-> |(grant & $past(req_valid))); // R2
  AST_CRIT_NEEDS_URG: assert property (@(posedge clk) disable iff (rst)
    critical |-> |(grant & $past(urgent_in) & urg_q)); // R4
  AST_URGENT_WINS: assert property (@(posedge clk) disable iff (rst)
    |(urg_q & urgent_in & req_valid) |=> critical); // R11
  AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HC_W'(HOLD_MAX)); // R10
endmodule

// File: tb/wr_age_arbiter_test.sv
module wr_age_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int BW   = 3;
  localparam int RW   = 14;
  localparam int PW   = 10;
  localparam int HOLD = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [N-1:0]      req_valid, urgent_in, cfg_pm_en, cfg_urg_en, cfg_age_en;
  logic [N*BW-1:0]   req_bank;
  logic [N*RW-1:0]   req_row;
  logic [N*PW-1:0]   cfg_prio;
  logic [N-1:0]      grant;
  logic              critical;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_age_arbiter #(.NPORTS(N), .BANK_W(BW), .ROW_W(RW), .HOLD_MAX(HOLD)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .urgent_in(urgent_in), .cfg_pm_en(cfg_pm_en),
    .cfg_urg_en(cfg_urg_en), .cfg_age_en(cfg_age_en), .cfg_prio(cfg_prio),
    .grant(grant), .critical(critical)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_tag(input int p, input int bank, input int row);
    req_bank[p*BW +: BW] = BW'(bank);
    req_row[p*RW +: RW]  = RW'(row);
  endtask

  task automatic do_reset(input logic [N-1:0] pm, input logic [N-1:0] urg,
                          input logic [N-1:0] age, input logic [PW-1:0] prio3);
    @(negedge clk);
    rst = 1'b1;
    req_valid = '0;
    urgent_in = '0;
    cfg_pm_en = pm;
    cfg_urg_en = urg;
    cfg_age_en = age;
    cfg_prio = '0;
    cfg_prio[3*PW +: PW] = prio3;
    for (int p = 0; p < N; p++) set_tag(p, p, 100 + p);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset('0, '0, '0, '0);
    chk("R1 grant after reset", grant, '0);
    chk("R1 critical after reset", {3'b0, critical}, '0);
  endtask

  task automatic t_round_robin();
    logic [N-1:0] exp [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001};
    do_reset('0, '0, '0, '0);
    req_valid = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk("R3 rotation", grant, exp[k]);
    end
    req_valid = 4'b0101;
    cyc();
    chk("R2 only requesting port", grant, 4'b0100);
    req_valid = '0;
    cyc();
    chk("R2 no request no grant", grant, '0);
  endtask

  task automatic t_urgent();
    do_reset('0, 4'b0100, '0, '0);
    cfg_urg_en = 4'b1111;
    req_valid = 4'b1111;
    cyc();
    chk("R3 first grant", grant, 4'b0001);
    urgent_in = 4'b1000;
    cyc();
    chk("R5/R1 disabled urgent ignored", grant, 4'b0010);
    chk("R5 critical stays low", {3'b0, critical}, '0);
    urgent_in = 4'b0100;
    cyc();
    chk("R4 urgent grant", grant, 4'b0100);
    chk("R4 critical", {3'b0, critical}, 4'b0001);
    cyc();
    chk("R4 urgent overrides rotation", grant, 4'b0100);
    chk("R4 critical held", {3'b0, critical}, 4'b0001);
    urgent_in = '0;
  endtask

  task automatic t_urgent_vs_hold();
    do_reset(4'b0001, 4'b0100, '0, '0);
    req_valid = 4'b0101;
    cyc();
    chk("R8 first grant", grant, 4'b0001);
    cyc();
    chk("R8 page hold", grant, 4'b0001);
    urgent_in = 4'b0100;
    cyc();
    chk("R11 urgent breaks hold", grant, 4'b0100);
    chk("R11 critical", {3'b0, critical}, 4'b0001);
    urgent_in = '0;
  endtask

  task automatic t_row_change();
    do_reset(4'b0001, '0, '0, '0);
    req_valid = 4'b0011;
    repeat (3) cyc();
    chk("R8 hold third cycle", grant, 4'b0001);
    set_tag(0, 0, 555);
    cyc();
    chk("R9 row change ends hold", grant, 4'b0010);
  endtask

  task automatic t_hold_limit();
    do_reset(4'b0001, '0, '0, '0);
    req_valid = 4'b1001;
    repeat (HOLD + 1) cyc();
    chk("R10 last held grant", grant, 4'b0001);
    cyc();
    chk("R10 hold limit reached", grant, 4'b1000);
  endtask

  task automatic t_aging();
    do_reset(4'b0001, '0, 4'b1000, 10'd7);
    req_valid = 4'b1001;
    repeat (4) cyc();
    chk("R6 not yet aged", grant, 4'b0001);
    cyc();
    chk("R6 aged port wins (load 4)", grant, 4'b1000);
    cyc();
    chk("R6 rotation after aged grant", grant, 4'b0001);
    repeat (3) cyc();
    chk("R6 reloaded counter", grant, 4'b0001);
    cyc();
    chk("R6 aged again after reload", grant, 4'b1000);
  endtask

  task automatic t_aging_off();
    do_reset(4'b0001, '0, '0, 10'd7);
    req_valid = 4'b1001;
    repeat (5) cyc();
    chk("R7 aging disabled no effect", grant, 4'b0001);
  endtask

  initial begin
    rst = 1'b1;
    req_valid = '0; urgent_in = '0; req_bank = '0; req_row = '0;
    cfg_pm_en = '0; cfg_urg_en = '0; cfg_age_en = '0; cfg_prio = '0;
    t_reset();
    t_round_robin();
    t_urgent();
    t_urgent_vs_hold();
    t_row_change();
    t_hold_limit();
    t_aging();
    t_aging_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule